// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is a synthesizable behavioural model of the command decoder and write sequencer of a small boot-block flash device. It is meant as a target for system-level testbenches. A host issues single-cycle bus writes (address plus data byte) and combinational reads. The last command written chooses what a read returns: array contents, the status byte or identifier codes. Program and block-erase operations run for a fixed number of clock cycles, set by parameters, and act on a small register array that stands in for the cell array.

Programming can only clear bits: the new word is the old word ANDed with the data. Erase sets every word of the target block to all ones. An erase can be suspended, so the array and the status can be read while it is paused, and then resumed. The lowest block is a boot block and only accepts program or erase while an unlock input is held high for the whole operation. A programming-voltage lockout input refuses all program and erase operations. A separate device reset input aborts any operation and leaves the affected data marked invalid (cleared to zero).

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the synchronous reset (`rst_n` low), the controller is in array-read mode, every word reads 0xFF, and the status byte reads 0x80.
- R2: Command 0xFF selects array reads, 0x70 selects status reads, and 0x90 selects identifier reads. In identifier mode, address 0 returns MFR_CODE, address 1 returns DEV_CODE, and any other address returns 0x00.
- R3: Command 0x40 followed by a write of (address, data) programs that word to old AND data. Status bit 7 (ready) reads 0 for exactly PROG_CYC cycles after the data write and then 1. Reads keep returning the status byte until a new command is written.
- R4: Command 0x20 followed by 0xD0 at any address erases the block holding that address (blocks of 2^BLK_AW words) to all ones. Status bit 7 reads 0 for exactly ERASE_CYC cycles. Other blocks are untouched.
- R5: In erase setup, any write other than 0xD0 enters the command-error state. Status then reads with bit 5 (erase error) and bit 7 set, and no block is changed.
- R6: Writing 0xB0 during an erase suspends it. Status then reads with bit 6 (suspended) and bit 7 both set. 0xFF gives array reads and 0x70 gives status reads while suspended. 0xD0 resumes the erase, and the busy cycles before and after the suspension add up to ERASE_CYC.
- R7: A program or erase of block BOOT_BLK is refused unless `boot_unlock` is high, both when the operation starts and on every busy cycle. A refusal sets status bit 1 (locked) plus bit 4 (program) or bit 5 (erase) and leaves the data unchanged.
- R8: While `vpp_low` is high, no program or erase starts or completes. A refusal sets status bit 3 (supply low) plus bit 4 or bit 5 and leaves the data unchanged.
- R9: Status bits 5, 4, 3 and 1 stay set until command 0x50 clears them. Changing the read mode does not clear them.
- R10: Pulling `dev_rst_n` low returns the controller to array-read mode and clears the status error bits. A program in progress leaves its target word at 0x00. An erase in progress or suspended leaves its whole block at 0x00.
- R11: While a program or erase is busy, writes are ignored, except 0xB0 during an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also fills the array with ones |
| dev_rst_n | input | 1 | Synchronous active-low device reset; aborts an operation |
| we | input | 1 | Write strobe, one cycle per bus write |
| addr | input | AW | Word address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| boot_unlock | input | 1 | High permits program or erase of the boot block |
| vpp_low | input | 1 | High refuses all program and erase operations |
| rdata | output | 8 | Read data: array, status or identifier, by mode |

## Verification
Assertions check on every cycle that the busy counter never decrements past zero and holds its value while an erase is suspended. They also check that no program or erase is committed to the boot block without the unlock input, or at all while the supply lockout is active. Further assertions cover the command-error transition, error-bit persistence without writes, and the return to array mode after a device reset. Only the bench scenarios can show the data effects: the AND-only programming result, block-exact erase, exact busy durations across a suspension, identifier codes, and the zeroed words left by an aborted operation, checked against a reference array under random program and erase traffic.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and constants for the flash command controller.
// Assumes 8-bit command bytes; the state encoding is internal to the block.
package flash_cmd_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_RD_ARRAY,
        ST_RD_STATUS,
        ST_RD_ID,
        ST_PG_SETUP,
        ST_PG_BUSY,
        ST_PG_DONE,
        ST_ER_SETUP,
        ST_ER_BUSY,
        ST_ER_SUSP,
        ST_ER_DONE,
        ST_ER_CMDERR
    } fsm_state_t;

    localparam logic [DATA_W-1:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [DATA_W-1:0] CMD_READ_STATUS = 8'h70;
    localparam logic [DATA_W-1:0] CMD_READ_ID     = 8'h90;
    localparam logic [DATA_W-1:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [DATA_W-1:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [DATA_W-1:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [DATA_W-1:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [DATA_W-1:0] CMD_CLEAR_STAT  = 8'h50;

endpackage

// File: rtl/fcsm_timer.sv
// Module: operation duration counter.
// Loads a cycle count when an operation starts and counts down while the
// controller requests it; holding (no dec) pauses it during erase suspend.
// Assumes the controller never requests a decrement at zero.
module fcsm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt
);

    // Purpose: hold, reload or decrement the remaining cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R3/R4: the controller completes at a count of one, so it never
    // asks the counter to step below zero.
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

endmodule

// File: rtl/fcsm_store.sv
// Module: register array standing in for the flash cells.
// Program ANDs data into one word, erase fills a block with ones, and the
// two invalidate strobes zero a word or a block after an aborted operation.
// Assumes at most one strobe of each kind per cycle.
module fcsm_store #(
    parameter int AW     = 6,
    parameter int BLK_AW = 4,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          kill_word_en,
    input  logic [AW-1:0] word_addr,
    input  logic [DW-1:0] prog_data,
    input  logic          erase_en,
    input  logic          kill_blk_en,
    input  logic [AW-BLK_AW-1:0] blk_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int WORDS = 1 << AW;
    localparam int BW    = AW - BLK_AW;

    logic [DW-1:0] mem [WORDS];

    // Purpose: apply erase, invalidate or program to each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (erase_en && (BW'(i >> BLK_AW) == blk_sel)) begin
                    mem[i] <= '1;
                end else if (kill_blk_en && (BW'(i >> BLK_AW) == blk_sel)) begin
                    mem[i] <= '0;
                end else if (kill_word_en && (word_addr == AW'(i))) begin
                    mem[i] <= '0;
                end else if (prog_en && (word_addr == AW'(i))) begin
                    mem[i] <= mem[i] & prog_data;
                end
            end
        end
    end

    // Purpose: asynchronous read port.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fcsm_ctrl.sv
// Module: command decoder and write sequencer.
// Decodes bus writes into read modes and operations, checks the lock and
// supply conditions at start and on every busy cycle, keeps the sticky error
// bits and drives the timer and the store strobes. Assumes one write per
// cycle at most and that dev_rst_n aborts whatever is running.
module fcsm_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BLK_AW    = 4,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    parameter int BOOT_BLK  = 0,
    parameter int CW        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              boot_unlock,
    input  logic              vpp_low,
    input  logic [CW-1:0]     tmr_cnt,
    output fsm_state_t        state,
    output logic              susp_arr,
    output logic [DATA_W-1:0] status,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output logic              tmr_dec,
    output logic              prog_en,
    output logic              erase_en,
    output logic              kill_word_en,
    output logic              kill_blk_en,
    output logic [AW-1:0]     tgt_addr,
    output logic [DATA_W-1:0] tgt_data
);

    localparam int BW = AW - BLK_AW;
    localparam logic [BW-1:0] BOOT_IDX = BW'(BOOT_BLK);

    fsm_state_t        st_q, st_d;
    logic [AW-1:0]     tgt_a_q, tgt_a_d;
    logic [DATA_W-1:0] tgt_d_q, tgt_d_d;
    logic              susp_q, susp_d;
    logic              e_er_q, e_er_d, e_pg_q, e_pg_d;
    logic              e_vpp_q, e_vpp_d, e_lock_q, e_lock_d;
    logic              boot_w, boot_t, lock_w, lock_t, ready;

    // Purpose: lock conditions for the incoming write and the held target.
    assign boot_w = (waddr[AW-1:BLK_AW] == BOOT_IDX);
    assign boot_t = (tgt_a_q[AW-1:BLK_AW] == BOOT_IDX);
    assign lock_w = boot_w && !boot_unlock;
    assign lock_t = boot_t && !boot_unlock;

    // Purpose: next-state, error-bit and strobe decode.
    always_comb begin
        st_d         = st_q;
        tgt_a_d      = tgt_a_q;
        tgt_d_d      = tgt_d_q;
        susp_d       = susp_q;
        e_er_d       = e_er_q;
        e_pg_d       = e_pg_q;
        e_vpp_d      = e_vpp_q;
        e_lock_d     = e_lock_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        tmr_dec      = 1'b0;
        prog_en      = 1'b0;
        erase_en     = 1'b0;
        kill_word_en = 1'b0;
        kill_blk_en  = 1'b0;
        case (st_q)
            ST_PG_SETUP: begin
                if (we) begin
                    tgt_a_d = waddr;
                    tgt_d_d = wdata;
                    if (vpp_low || lock_w) begin
                        e_pg_d   = 1'b1;
                        e_vpp_d  = e_vpp_q  | vpp_low;
                        e_lock_d = e_lock_q | lock_w;
                        st_d     = ST_PG_DONE;
                    end else begin
                        st_d     = ST_PG_BUSY;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(PROG_CYC);
                    end
                end
            end
            ST_PG_BUSY: begin
                tmr_dec = 1'b1;
                if (vpp_low || lock_t) begin
                    e_pg_d   = 1'b1;
                    e_vpp_d  = e_vpp_q  | vpp_low;
                    e_lock_d = e_lock_q | lock_t;
                    st_d     = ST_PG_DONE;
                end else if (tmr_cnt == CW'(1)) begin
                    prog_en = 1'b1;
                    st_d    = ST_PG_DONE;
                end
            end
            ST_ER_SETUP: begin
                if (we) begin
                    if (wdata == CMD_CONFIRM) begin
                        tgt_a_d = waddr;
                        if (vpp_low || lock_w) begin
                            e_er_d   = 1'b1;
                            e_vpp_d  = e_vpp_q  | vpp_low;
                            e_lock_d = e_lock_q | lock_w;
                            st_d     = ST_ER_DONE;
                        end else begin
                            st_d     = ST_ER_BUSY;
                            tmr_load = 1'b1;
                            tmr_val  = CW'(ERASE_CYC);
                        end
                    end else begin
                        e_er_d = 1'b1;
                        st_d   = ST_ER_CMDERR;
                    end
                end
            end
            ST_ER_BUSY: begin
                tmr_dec = 1'b1;
                if (vpp_low || lock_t) begin
                    e_er_d   = 1'b1;
                    e_vpp_d  = e_vpp_q  | vpp_low;
                    e_lock_d = e_lock_q | lock_t;
                    st_d     = ST_ER_DONE;
                end else if (tmr_cnt == CW'(1)) begin
                    erase_en = 1'b1;
                    st_d     = ST_ER_DONE;
                end else if (we && (wdata == CMD_SUSPEND)) begin
                    susp_d = 1'b0;
                    st_d   = ST_ER_SUSP;
                end
            end
            ST_ER_SUSP: begin
                if (we) begin
                    if (wdata == CMD_READ_ARRAY) begin
                        susp_d = 1'b1;
                    end else if (wdata == CMD_READ_STATUS) begin
                        susp_d = 1'b0;
                    end else if (wdata == CMD_CONFIRM) begin
                        st_d = ST_ER_BUSY;
                    end
                end
            end
            default: begin
                if (we) begin
                    case (wdata)
                        CMD_READ_ARRAY:  st_d = ST_RD_ARRAY;
                        CMD_READ_STATUS: st_d = ST_RD_STATUS;
                        CMD_READ_ID:     st_d = ST_RD_ID;
                        CMD_PROG_SETUP:  st_d = ST_PG_SETUP;
                        CMD_ERASE_SETUP: st_d = ST_ER_SETUP;
                        CMD_CLEAR_STAT: begin
                            e_er_d   = 1'b0;
                            e_pg_d   = 1'b0;
                            e_vpp_d  = 1'b0;
                            e_lock_d = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
        if (!dev_rst_n) begin
            st_d         = ST_RD_ARRAY;
            susp_d       = 1'b0;
            e_er_d       = 1'b0;
            e_pg_d       = 1'b0;
            e_vpp_d      = 1'b0;
            e_lock_d     = 1'b0;
            tmr_load     = 1'b0;
            prog_en      = 1'b0;
            erase_en     = 1'b0;
            kill_word_en = (st_q == ST_PG_BUSY);
            kill_blk_en  = (st_q == ST_ER_BUSY) || (st_q == ST_ER_SUSP);
        end
    end

    // Purpose: state and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_RD_ARRAY;
            tgt_a_q  <= '0;
            tgt_d_q  <= '0;
            susp_q   <= 1'b0;
            e_er_q   <= 1'b0;
            e_pg_q   <= 1'b0;
            e_vpp_q  <= 1'b0;
            e_lock_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            tgt_a_q  <= tgt_a_d;
            tgt_d_q  <= tgt_d_d;
            susp_q   <= susp_d;
            e_er_q   <= e_er_d;
            e_pg_q   <= e_pg_d;
            e_vpp_q  <= e_vpp_d;
            e_lock_q <= e_lock_d;
        end
    end

    // Purpose: status byte assembly and outputs.
    assign ready    = (st_q != ST_PG_BUSY) && (st_q != ST_ER_BUSY);
    assign status   = {ready, (st_q == ST_ER_SUSP), e_er_q, e_pg_q,
                       e_vpp_q, 1'b0, e_lock_q, 1'b0};
    assign state    = st_q;
    assign susp_arr = susp_q;
    assign tgt_addr = tgt_a_q;
    assign tgt_data = tgt_d_q;

    // R5: a non-confirm write in erase setup lands in the error state.
    p_cmderr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ER_SETUP && we && wdata != CMD_CONFIRM && dev_rst_n)
        |=> (st_q == ST_ER_CMDERR && status[5]));

    // R7: nothing is committed to the boot block without the unlock input.
    p_boot_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_en || erase_en) && boot_t) |-> boot_unlock);

    // R8: nothing is committed while the supply lockout is active.
    p_vpp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> !vpp_low);

    // R9: with no bus write and no device reset, the erase error bit persists.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !we && dev_rst_n) |=> status[5]);

    // R10: a device reset returns to array mode with a clean status.
    p_devrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |=> (st_q == ST_RD_ARRAY && status == 8'h80));

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Module: top of the flash command controller model.
// Ties the sequencer, the timer and the register store together and selects
// the read data by mode. Assumes ERASE_CYC >= 1 and PROG_CYC >= 1.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int          AW        = 6,
    parameter int          BLK_AW    = 4,
    parameter int          PROG_CYC  = 6,
    parameter int          ERASE_CYC = 20,
    parameter int          BOOT_BLK  = 0,
    parameter logic [7:0]  MFR_CODE  = 8'hA7,
    parameter logic [7:0]  DEV_CODE  = 8'h3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          boot_unlock,
    input  logic          vpp_low,
    output logic [7:0]    rdata
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    fsm_state_t        state;
    logic              susp_arr, tmr_load, tmr_dec;
    logic              prog_en, erase_en, kill_word_en, kill_blk_en;
    logic [CW-1:0]     tmr_val, tmr_cnt;
    logic [AW-1:0]     tgt_addr;
    logic [DATA_W-1:0] tgt_data, status, arr_data, id_data;

    fcsm_ctrl #(
        .AW(AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .BOOT_BLK(BOOT_BLK), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .we(we),
        .waddr(addr), .wdata(wdata), .boot_unlock(boot_unlock),
        .vpp_low(vpp_low), .tmr_cnt(tmr_cnt), .state(state),
        .susp_arr(susp_arr), .status(status), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .tmr_dec(tmr_dec), .prog_en(prog_en),
        .erase_en(erase_en), .kill_word_en(kill_word_en),
        .kill_blk_en(kill_blk_en), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    fcsm_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .dec(tmr_dec), .cnt(tmr_cnt)
    );

    fcsm_store #(.AW(AW), .BLK_AW(BLK_AW), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
        .kill_word_en(kill_word_en), .word_addr(tgt_addr),
        .prog_data(tgt_data), .erase_en(erase_en), .kill_blk_en(kill_blk_en),
        .blk_sel(tgt_addr[AW-1:BLK_AW]), .rd_addr(addr), .rd_data(arr_data)
    );

    // Purpose: identifier codes by offset.
    always_comb begin
        if (addr == AW'(0))      id_data = MFR_CODE;
        else if (addr == AW'(1)) id_data = DEV_CODE;
        else                     id_data = '0;
    end

    // Purpose: read data selection by current mode.
    always_comb begin
        case (state)
            ST_RD_ARRAY: rdata = arr_data;
            ST_RD_ID:    rdata = id_data;
            ST_ER_SUSP:  rdata = susp_arr ? arr_data : status;
            default:     rdata = status;
        endcase
    end

    // R6: the remaining erase time is frozen while suspended.
    p_susp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ER_SUSP && dev_rst_n) |=> $stable(tmr_cnt));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

    localparam int         CLK_PERIOD = 10;
    localparam int         AW         = 6;
    localparam int         BLK_AW     = 4;
    localparam int         PROG_CYC   = 6;
    localparam int         ERASE_CYC  = 20;
    localparam logic [7:0] MFR        = 8'hA7;
    localparam logic [7:0] DEV        = 8'h3C;
    localparam int         WORDS      = 1 << AW;

    logic clk = 1'b0;
    logic rst_n, dev_rst_n, we, boot_unlock, vpp_low;
    logic [AW-1:0] addr;
    logic [7:0] wdata, rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] ref_mem [WORDS];

    flash_cmd_ctrl #(
        .AW(AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .BOOT_BLK(0), .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .we(we), .addr(addr),
        .wdata(wdata), .boot_unlock(boot_unlock), .vpp_low(vpp_low),
        .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] st_exp(input bit rdy, input bit sus,
        input bit eer, input bit epg, input bit evpp, input bit elock);
        return {rdy, sus, eer, epg, evpp, 1'b0, elock, 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after a falling edge; the write commits at the next rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Counts the busy samples, one per cycle, until ready reads 1.
    task automatic poll(output int n);
        logic [7:0] s;
        n = 0;
        for (int g = 0; g < 1000; g++) begin
            rd('0, s);
            if (s[7]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d,
                           output int n);
        wr(a, 8'h40);
        wr(a, d);
        poll(n);
    endtask

    task automatic do_erase(input logic [AW-1:0] a, output int n);
        wr(a, 8'h20);
        wr(a, 8'hD0);
        poll(n);
    endtask

    task automatic fill_ref(input int blk, input logic [7:0] v);
        for (int i = 0; i < (1 << BLK_AW); i++) ref_mem[blk*(1<<BLK_AW)+i] = v;
    endtask

    initial begin
        logic [7:0] v;
        int n, m;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        rst_n = 1'b0; dev_rst_n = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        boot_unlock = 1'b0; vpp_low = 1'b0;
        for (int i = 0; i < WORDS; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(6'd5, v);   check("R1 array after reset", v, 8'hFF);
        rd(6'd0, v);   check("R1 array word 0", v, 8'hFF);
        wr(6'd0, 8'h70);
        rd(6'd0, v);   check("R1 status after reset", v, 8'h80);

        // R2: identifier and mode selection
        wr(6'd0, 8'h90);
        rd(6'd0, v);   check("R2 id offset 0", v, MFR);
        rd(6'd1, v);   check("R2 id offset 1", v, DEV);
        rd(6'd2, v);   check("R2 id other offset", v, 8'h00);
        wr(6'd0, 8'hFF);
        rd(6'd9, v);   check("R2 back to array", v, 8'hFF);

        // R3: program timing, result and status persistence
        do_prog(6'd20, 8'hA5, n);
        check_int("R3 program busy cycles", n, PROG_CYC);
        rd(6'd20, v);  check("R3 status after program", v, 8'h80);
        wr(6'd0, 8'hFF);
        rd(6'd20, v);  check("R3 programmed word", v, 8'hA5);
        ref_mem[20] = 8'hA5;

        // R11: a write during programming is ignored
        wr(6'd20, 8'h40);
        wr(6'd20, 8'h0F);
        wr(6'd20, 8'hFF);
        poll(n);
        rd(6'd20, v);  check("R11 write while busy ignored", v, 8'h80);
        wr(6'd0, 8'hFF);
        rd(6'd20, v);  check("R3 program is AND of old and data", v, 8'h05);
        ref_mem[20] = 8'h05;

        // R4: block erase
        do_prog(6'd35, 8'h5A, n);
        ref_mem[35] = 8'h5A;
        do_erase(6'd17, n);
        check_int("R4 erase busy cycles", n, ERASE_CYC);
        wr(6'd0, 8'hFF);
        rd(6'd20, v);  check("R4 erased word", v, 8'hFF);
        rd(6'd35, v);  check("R4 other block kept", v, 8'h5A);
        ref_mem[20] = 8'hFF;

        // R5 and R9: erase command error and clearing
        wr(6'd35, 8'h20);
        wr(6'd35, 8'hFF);
        rd(6'd0, v);   check("R5 command error status", v, st_exp(1,0,1,0,0,0));
        wr(6'd0, 8'h50);
        rd(6'd0, v);   check("R9 clear status", v, 8'h80);
        wr(6'd0, 8'hFF);
        rd(6'd35, v);  check("R5 no erase on error", v, 8'h5A);

        // R6: suspend and resume
        do_prog(6'd40, 8'h3C, n);
        ref_mem[40] = 8'h3C;
        wr(6'd40, 8'h20);
        wr(6'd40, 8'hD0);
        n = 0;
        for (int i = 0; i < 3; i++) begin
            rd('0, v);
            if (!v[7]) n++;
            @(negedge clk);
        end
        wr(6'd40, 8'hB0);
        n++;
        rd(6'd0, v);   check("R6 suspended status", v, st_exp(1,1,0,0,0,0));
        wr(6'd0, 8'hFF);
        rd(6'd40, v);  check("R6 array read while suspended", v, 8'h3C);
        wr(6'd0, 8'h70);
        rd(6'd40, v);  check("R6 status read while suspended", v, 8'hC0);
        wr(6'd40, 8'hD0);
        poll(m);
        check_int("R6 total erase cycles across suspend", n + m, ERASE_CYC);
        wr(6'd0, 8'hFF);
        rd(6'd40, v);  check("R6 erase finished after resume", v, 8'hFF);
        rd(6'd35, v);  check("R6 same block word erased", v, 8'hFF);
        fill_ref(2, 8'hFF);

        // R7: boot block lock
        do_prog(6'd3, 8'h00, n);
        rd(6'd0, v);   check("R7 locked program status", v, st_exp(1,0,0,1,0,1));
        wr(6'd0, 8'hFF);
        rd(6'd3, v);   check("R7 locked program no change", v, 8'hFF);
        wr(6'd0, 8'h70);
        rd(6'd0, v);   check("R9 error survives mode change", v, 8'h92);
        wr(6'd0, 8'h50);
        do_erase(6'd0, n);
        rd(6'd0, v);   check("R7 locked erase status", v, st_exp(1,0,1,0,0,1));
        wr(6'd0, 8'h50);
        boot_unlock = 1'b1;
        do_prog(6'd3, 8'h11, n);
        rd(6'd0, v);   check("R7 unlocked program status", v, 8'h80);
        wr(6'd0, 8'hFF);
        rd(6'd3, v);   check("R7 unlocked program result", v, 8'h11);
        ref_mem[3] = 8'h11;
        wr(6'd4, 8'h40);
        wr(6'd4, 8'h00);
        @(negedge clk); @(negedge clk);
        boot_unlock = 1'b0;
        poll(n);
        rd(6'd0, v);   check("R7 unlock dropped mid program", v, 8'h92);
        wr(6'd0, 8'hFF);
        rd(6'd4, v);   check("R7 dropped unlock no change", v, 8'hFF);
        wr(6'd0, 8'h50);

        // R8: supply lockout
        vpp_low = 1'b1;
        do_prog(6'd50, 8'h00, n);
        rd(6'd0, v);   check("R8 vpp program refused", v, st_exp(1,0,0,1,1,0));
        wr(6'd0, 8'h50);
        do_erase(6'd50, n);
        rd(6'd0, v);   check("R8 vpp erase refused", v, st_exp(1,0,1,0,1,0));
        wr(6'd0, 8'h50);
        vpp_low = 1'b0;
        do_prog(6'd41, 8'h77, n);
        ref_mem[41] = 8'h77;
        wr(6'd41, 8'h20);
        wr(6'd41, 8'hD0);
        @(negedge clk); @(negedge clk);
        vpp_low = 1'b1;
        poll(n);
        vpp_low = 1'b0;
        rd(6'd0, v);   check("R8 vpp dropped mid erase", v, 8'hA8);
        wr(6'd0, 8'hFF);
        rd(6'd41, v);  check("R8 block kept after refusal", v, 8'h77);
        wr(6'd0, 8'h50);

        // R10: device reset aborts
        wr(6'd36, 8'h40);
        wr(6'd36, 8'h55);
        @(negedge clk);
        dev_rst_n = 1'b0;
        @(negedge clk);
        dev_rst_n = 1'b1;
        rd(6'd36, v);  check("R10 aborted program word invalid", v, 8'h00);
        rd(6'd41, v);  check("R10 array mode after reset", v, 8'h77);
        ref_mem[36] = 8'h00;
        wr(6'd0, 8'h70);
        rd(6'd0, v);   check("R10 status after device reset", v, 8'h80);
        do_prog(6'd50, 8'h12, n);
        wr(6'd48, 8'h20);
        wr(6'd48, 8'hD0);
        @(negedge clk);
        wr(6'd48, 8'hB0);
        dev_rst_n = 1'b0;
        @(negedge clk);
        dev_rst_n = 1'b1;
        rd(6'd48, v);  check("R10 aborted erase block invalid", v, 8'h00);
        rd(6'd63, v);  check("R10 aborted erase last word", v, 8'h00);
        fill_ref(3, 8'h00);

        // Random traffic against the reference array
        boot_unlock = 1'b0;
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [AW-1:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 2);
            if (op == 0) begin
                a = AW'($urandom_range(16, WORDS - 1));
                d = 8'($urandom);
                do_prog(a, d, n);
                check_int("R3 random program cycles", n, PROG_CYC);
                ref_mem[a] = ref_mem[a] & d;
            end else if (op == 1) begin
                int b;
                b = $urandom_range(1, 3);
                a = AW'(b * (1 << BLK_AW) + $urandom_range(0, 15));
                do_erase(a, n);
                check_int("R4 random erase cycles", n, ERASE_CYC);
                fill_ref(b, 8'hFF);
            end else begin
                a = AW'($urandom_range(0, WORDS - 1));
                wr(a, 8'hFF);
                rd(a, v);
                check("R4 random array read", v, ref_mem[a]);
            end
        end
        wr(6'd0, 8'hFF);
        for (int i = 0; i < WORDS; i++) begin
            rd(AW'(i), v);
            check("R3 final array sweep", v, ref_mem[i]);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule